// File: doc/BRIEF.md
# DMA Channel Arm and Completion-Interrupt Controller

This block is the control layer of a five-channel DMA engine. It keeps one armed bit per channel and a five-bit trigger selector per channel. It also turns software requests, peripheral event pulses and chained completions into one-cycle start strobes for the data movers. It records channel completions in sticky flags and drives one CPU interrupt line, which is gated per channel by a mask. Descriptor fetching and data movement sit outside the block; the datapath only returns a completion pulse for each channel.

Software reaches the block through a byte-wide write port with these addresses:

| Address | Function |
|---|---|
| 0 | Arm / abort |
| 1 | Software request |
| 2 | Completion flags |
| 3 | Interrupt mask |
| 4 | Repeat |
| 5 + n | Trigger selector of channel n |

Bit 7 of a write to the arm register selects abort mode. In abort mode, only the channels whose bits are 1 are disarmed. Aborts never leave a completion flag behind.

Top module: `dma_arm_ctrl`

## Requirements
- R1: While reset is low and after it is released, start strobes, armed bits, completion flags and the interrupt are all 0. Masks, repeat bits and trigger selectors are also reset to 0.
- R2: A write to address 0 with bit 7 clear loads the armed bits from data bits 4:0. Armed bit n is data bit n, and this write replaces all armed bits.
- R3: A write to address 0 with bit 7 set disarms every channel whose data bit is 1. Channels written as 0 keep their armed state.
- R4: An aborted channel gets no completion flag, even when its completion pulse arrives in the same cycle as the abort. That cancelled completion does not start a channel chained to it.
- R5: A completion pulse on channel n sets flag n at the next clock edge, whatever the value of mask bit n.
- R6: The interrupt output is 1 exactly when some flag is set and its mask bit (address 3, bit n) is 1. A flag that is already set raises the interrupt as soon as its mask bit is written to 1.
- R7: A write to address 2 clears every flag whose data bit is 0 and leaves flags written as 1 unchanged. A completion in the same cycle keeps its flag set.
- R8: A write to address 1 gives a start strobe, one cycle later, to each armed channel whose data bit is 1. Unarmed channels get no strobe.
- R9: A channel whose selector is 0 ignores all hardware triggers.
- R10: Selector value 1 starts channel n on the completion of channel n-1. Channel 0 chains to channel 4.
- R11: Selector value k of 2 or more starts the channel on pulse input bit k-2.
- R12: A channel disarms at the completion edge unless its repeat bit (address 4, bit n) is 1. No channel becomes armed except through a write of the kind R2 describes.
- R13: A start strobe lasts one cycle. It is issued only for a channel that was armed in the cycle in which the start event occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 8 | Write data |
| trig_i | input | 30 | Peripheral event pulses; bit k-2 serves selector value k |
| done_i | input | 5 | Per-channel completion pulses from the datapath |
| start_o | output | 5 | Per-channel start strobes |
| armed_o | output | 5 | Armed state of each channel |
| flag_o | output | 5 | Sticky completion flags |
| irq_o | output | 1 | CPU interrupt |

## Verification
The bench targets the same-cycle collisions:
- **Abort with completion.** A design in which the completion wins would leave a flag set and start the chained channel.
- **Flag clear with completion.** A design in which the clear wins would lose an event.

It also checks three cases where a wrong design shows at the outputs:
- **Stale flag.** A flag latched while its mask was 0 must raise the interrupt once the mask is set. A design that gates the flag with the mask would stay silent.
- **Chain wrap.** Channel 0 must follow channel 4. A design without the wrap would never strobe channel 0.
- **Repeat bit.** A channel with its repeat bit set must stay armed through a completion. A design that ignores the repeat bit would disarm it.

// File: rtl/dma_arm_pkg.sv
// Package: register addresses and bit positions shared by the DMA arm controller.
// Assumes a byte-wide write port and at most seven channels (bit 7 is the abort mode bit).
package dma_arm_pkg;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int ABORT_BIT = 7;

    localparam logic [ADDR_W-1:0] A_ARM   = 4'd0;
    localparam logic [ADDR_W-1:0] A_REQ   = 4'd1;
    localparam logic [ADDR_W-1:0] A_FLAG  = 4'd2;
    localparam logic [ADDR_W-1:0] A_MASK  = 4'd3;
    localparam logic [ADDR_W-1:0] A_RPT   = 4'd4;
    localparam logic [ADDR_W-1:0] A_TRIG0 = 4'd5;
endpackage

// File: rtl/dma_trig_sel.sv
// Module: per-channel hardware trigger multiplexer.
// Selector 0 means no hardware trigger. Selector 1 chains the channel to the completion
// of the channel before it (channel 0 wraps to the last channel). Selector k >= 2 picks
// pulse bit k-2. Assumes the chain inputs already have aborted completions removed.
module dma_trig_sel #(
    parameter int NUM_CH     = 5,
    parameter int TRIG_W     = 5,
    parameter int NUM_PERIPH = 30
) (
    input  logic [NUM_CH*TRIG_W-1:0] sel_i,
    input  logic [NUM_PERIPH-1:0]    periph_i,
    input  logic [NUM_CH-1:0]        chain_i,
    output logic [NUM_CH-1:0]        hw_evt_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int PREV = (c + NUM_CH - 1) % NUM_CH;
        logic [TRIG_W-1:0] sel;
        assign sel = sel_i[c*TRIG_W +: TRIG_W];

        // Purpose: decode this channel's selector into a single event pulse.
        always_comb begin
            hw_evt_o[c] = 1'b0;
            if (sel == TRIG_W'(1)) begin
                hw_evt_o[c] = chain_i[PREV];
            end else if (int'(sel) >= 2 && int'(sel) - 2 < NUM_PERIPH) begin
                hw_evt_o[c] = periph_i[int'(sel) - 2];
            end
        end
    end
endmodule

// File: rtl/dma_arm_reg.sv
// Module: armed-bit register file and start-strobe generator.
// A plain write replaces the armed bits. An abort clears the selected bits. A completion
// clears the bit unless the repeat bit is set. A start strobe is registered one cycle
// after the event and is given only to channels that are armed and not being aborted.
module dma_arm_reg #(
    parameter int NUM_CH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_wr_i,
    input  logic [NUM_CH-1:0] arm_data_i,
    input  logic [NUM_CH-1:0] abort_sel_i,
    input  logic [NUM_CH-1:0] done_i,
    input  logic [NUM_CH-1:0] repeat_i,
    input  logic [NUM_CH-1:0] start_evt_i,
    output logic [NUM_CH-1:0] armed_o,
    output logic [NUM_CH-1:0] start_o
);
    logic [NUM_CH-1:0] armed_q, armed_d, start_q;

    // Purpose: next armed state from the write, abort and auto-disarm rules.
    always_comb begin
        if (arm_wr_i) begin
            armed_d = arm_data_i;
        end else begin
            armed_d = armed_q & ~(done_i & ~repeat_i) & ~abort_sel_i;
        end
    end

    // Purpose: hold the armed bits and register the start strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= '0;
            start_q <= '0;
        end else begin
            armed_q <= armed_d;
            start_q <= armed_q & ~abort_sel_i & start_evt_i;
        end
    end

    assign armed_o = armed_q;
    assign start_o = start_q;
endmodule

// File: rtl/dma_flag_irq.sv
// Module: sticky completion flags and the masked interrupt.
// Flags latch each completion regardless of the mask. Software clears a flag by writing 0
// to it. A completion in the same cycle as the clear wins. Assumes completions of aborted
// channels have already been removed by the caller.
module dma_flag_irq #(
    parameter int NUM_CH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_wr_i,
    input  logic [NUM_CH-1:0] flag_data_i,
    input  logic [NUM_CH-1:0] done_i,
    input  logic [NUM_CH-1:0] mask_i,
    output logic [NUM_CH-1:0] flag_o,
    output logic              irq_o
);
    logic [NUM_CH-1:0] flag_q;

    // Purpose: apply the write-zero-to-clear, then OR in this cycle's completions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else if (flag_wr_i) begin
            flag_q <= (flag_q & flag_data_i) | done_i;
        end else begin
            flag_q <= flag_q | done_i;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = |(flag_q & mask_i);
endmodule

// File: rtl/dma_arm_ctrl.sv
// Module: top of the DMA arm and interrupt controller.
// Decodes the write port, holds the mask, repeat and trigger-selector registers, and ties
// together the trigger mux, the armed-bit logic and the flag/interrupt logic.
// Assumes NUM_CH <= 7 and that the trigger-selector addresses fit in ADDR_W bits.
module dma_arm_ctrl
    import dma_arm_pkg::*;
#(
    parameter int NUM_CH     = 5,
    parameter int TRIG_W     = 5,
    parameter int NUM_PERIPH = 30
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic [NUM_PERIPH-1:0] trig_i,
    input  logic [NUM_CH-1:0]     done_i,
    output logic [NUM_CH-1:0]     start_o,
    output logic [NUM_CH-1:0]     armed_o,
    output logic [NUM_CH-1:0]     flag_o,
    output logic                  irq_o
);
    localparam int SEL_BITS = NUM_CH * TRIG_W;

    logic [NUM_CH-1:0]   ch_bits, abort_sel, arm_data, sw_req, done_eff, hw_evt;
    logic [NUM_CH-1:0]   mask_q, repeat_q;
    logic [SEL_BITS-1:0] sel_q;
    logic                arm_hit, arm_wr, abort_wr, flag_wr;
    logic                unused_bits;

    assign ch_bits     = wr_data_i[NUM_CH-1:0];
    assign unused_bits = ^wr_data_i[DATA_W-2:TRIG_W];

    // Purpose: decode the write port into arm, abort, request and flag-write actions.
    always_comb begin
        arm_hit   = wr_en_i && (wr_addr_i == A_ARM);
        abort_wr  = arm_hit && wr_data_i[ABORT_BIT];
        arm_wr    = arm_hit && !wr_data_i[ABORT_BIT];
        flag_wr   = wr_en_i && (wr_addr_i == A_FLAG);
        abort_sel = abort_wr ? ch_bits : '0;
        arm_data  = ch_bits;
        sw_req    = (wr_en_i && (wr_addr_i == A_REQ)) ? ch_bits : '0;
        done_eff  = done_i & ~abort_sel;
    end

    // Purpose: hold the interrupt mask and the repeat bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            repeat_q <= '0;
        end else if (wr_en_i && wr_addr_i == A_MASK) begin
            mask_q   <= ch_bits;
        end else if (wr_en_i && wr_addr_i == A_RPT) begin
            repeat_q <= ch_bits;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        // Purpose: hold the trigger selector of channel c.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[c*TRIG_W +: TRIG_W] <= '0;
            end else if (wr_en_i && wr_addr_i == A_TRIG0 + ADDR_W'(c)) begin
                sel_q[c*TRIG_W +: TRIG_W] <= wr_data_i[TRIG_W-1:0];
            end
        end
    end

    dma_trig_sel #(
        .NUM_CH     (NUM_CH),
        .TRIG_W     (TRIG_W),
        .NUM_PERIPH (NUM_PERIPH)
    ) u_trig (
        .sel_i    (sel_q),
        .periph_i (trig_i),
        .chain_i  (done_eff),
        .hw_evt_o (hw_evt)
    );

    dma_arm_reg #(
        .NUM_CH (NUM_CH)
    ) u_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_wr_i    (arm_wr),
        .arm_data_i  (arm_data),
        .abort_sel_i (abort_sel),
        .done_i      (done_eff),
        .repeat_i    (repeat_q),
        .start_evt_i (sw_req | hw_evt),
        .armed_o     (armed_o),
        .start_o     (start_o)
    );

    dma_flag_irq #(
        .NUM_CH (NUM_CH)
    ) u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .flag_wr_i   (flag_wr),
        .flag_data_i (ch_bits),
        .done_i      (done_eff),
        .mask_i      (mask_q),
        .flag_o      (flag_o),
        .irq_o       (irq_o)
    );
endmodule

// File: rtl/dma_arm_ctrl_chk.sv
// Module: assertion checker for dma_arm_ctrl, attached through bind.
// Observes only the ports of the top module.
module dma_arm_ctrl_chk
    import dma_arm_pkg::*;
#(
    parameter int NUM_CH     = 5,
    parameter int NUM_PERIPH = 30
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en_i,
    input logic [ADDR_W-1:0]     wr_addr_i,
    input logic [DATA_W-1:0]     wr_data_i,
    input logic [NUM_PERIPH-1:0] trig_i,
    input logic [NUM_CH-1:0]     done_i,
    input logic [NUM_CH-1:0]     start_o,
    input logic [NUM_CH-1:0]     armed_o,
    input logic [NUM_CH-1:0]     flag_o,
    input logic                  irq_o
);
    logic abort_w, arm_w, unused_trig;

    assign abort_w     = wr_en_i && wr_addr_i == A_ARM && wr_data_i[ABORT_BIT];
    assign arm_w       = wr_en_i && wr_addr_i == A_ARM && !wr_data_i[ABORT_BIT];
    assign unused_trig = ^trig_i;

    // R3: the selected channels are disarmed after an abort write.
    assert_abort_disarms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        abort_w |=> ((armed_o & $past(wr_data_i[NUM_CH-1:0])) == '0));

    // R3: channels written as 0 keep their state when no completion interferes.
    assert_abort_spares_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_w && done_i == '0) |=>
        ((armed_o & ~$past(wr_data_i[NUM_CH-1:0])) == ($past(armed_o) & ~$past(wr_data_i[NUM_CH-1:0]))));

    // R4: an aborted channel's flag never rises at the abort edge.
    assert_abort_no_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        abort_w |=> ((flag_o & ~$past(flag_o) & $past(wr_data_i[NUM_CH-1:0])) == '0));

    // R5: a completion with no abort latches its flag.
    assert_done_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i != '0 && !abort_w) |=> ((flag_o & $past(done_i)) == $past(done_i)));

    // R6: no interrupt without a pending flag.
    assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o == '0) |-> !irq_o);

    // R12: armed bits rise only after a plain arm write.
    assert_arm_only_by_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((armed_o & ~$past(armed_o)) != '0) |-> $past(arm_w));

    // R13: a strobe is given only to a channel that was armed in the previous cycle.
    assert_start_needs_arm_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o != '0) |-> ((start_o & ~$past(armed_o)) == '0));
endmodule

bind dma_arm_ctrl dma_arm_ctrl_chk #(
    .NUM_CH     (NUM_CH),
    .NUM_PERIPH (NUM_PERIPH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .trig_i    (trig_i),
    .done_i    (done_i),
    .start_o   (start_o),
    .armed_o   (armed_o),
    .flag_o    (flag_o),
    .irq_o     (irq_o)
);

// File: tb/dma_arm_ctrl_tb.sv
// Bench: a vector table walked by one loop, then directed corner-case tests.
module dma_arm_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en_i;
    logic [3:0]  wr_addr_i;
    logic [7:0]  wr_data_i;
    logic [29:0] trig_i;
    logic [4:0]  done_i;
    logic [4:0]  start_o, armed_o, flag_o;
    logic        irq_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    dma_arm_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .trig_i    (trig_i),
        .done_i    (done_i),
        .start_o   (start_o),
        .armed_o   (armed_o),
        .flag_o    (flag_o),
        .irq_o     (irq_o)
    );

    typedef struct packed {
        logic       we;
        logic [3:0] addr;
        logic [7:0] data;
        logic [4:0] done;
        logic [7:0] trig;
        logic [4:0] e_start;
        logic [4:0] e_armed;
        logic [4:0] e_flag;
        logic       e_irq;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd6, 8'h01, 5'h00, 8'h00, 5'h00, 5'h00, 5'h00, 1'b0},
        '{1'b1, 4'd7, 8'h02, 5'h00, 8'h00, 5'h00, 5'h00, 5'h00, 1'b0},
        '{1'b1, 4'd8, 8'h09, 5'h00, 8'h00, 5'h00, 5'h00, 5'h00, 1'b0},
        '{1'b1, 4'd0, 8'h0F, 5'h00, 8'h00, 5'h00, 5'h0F, 5'h00, 1'b0},
        '{1'b1, 4'd1, 8'h01, 5'h00, 8'h00, 5'h01, 5'h0F, 5'h00, 1'b0},
        '{1'b0, 4'd0, 8'h00, 5'h01, 8'h00, 5'h02, 5'h0E, 5'h01, 1'b0},
        '{1'b0, 4'd0, 8'h00, 5'h00, 8'h01, 5'h04, 5'h0E, 5'h01, 1'b0},
        '{1'b0, 4'd0, 8'h00, 5'h00, 8'h80, 5'h08, 5'h0E, 5'h01, 1'b0},
        '{1'b0, 4'd0, 8'h00, 5'h00, 8'h02, 5'h00, 5'h0E, 5'h01, 1'b0},
        '{1'b1, 4'd3, 8'h01, 5'h00, 8'h00, 5'h00, 5'h0E, 5'h01, 1'b1},
        '{1'b1, 4'd2, 8'h1E, 5'h00, 8'h00, 5'h00, 5'h0E, 5'h00, 1'b0},
        '{1'b1, 4'd2, 8'h00, 5'h02, 8'h00, 5'h00, 5'h0C, 5'h02, 1'b0},
        '{1'b1, 4'd0, 8'h84, 5'h04, 8'h00, 5'h00, 5'h08, 5'h02, 1'b0},
        '{1'b1, 4'd4, 8'h08, 5'h00, 8'h00, 5'h00, 5'h08, 5'h02, 1'b0},
        '{1'b0, 4'd0, 8'h00, 5'h08, 8'h00, 5'h00, 5'h08, 5'h0A, 1'b0},
        '{1'b1, 4'd0, 8'h10, 5'h00, 8'h00, 5'h00, 5'h10, 5'h0A, 1'b0},
        '{1'b0, 4'd0, 8'h00, 5'h00, 8'hFF, 5'h00, 5'h10, 5'h0A, 1'b0},
        '{1'b1, 4'd1, 8'h1F, 5'h00, 8'h00, 5'h10, 5'h10, 5'h0A, 1'b0},
        '{1'b0, 4'd0, 8'h00, 5'h00, 8'h00, 5'h00, 5'h10, 5'h0A, 1'b0}
    };

    // Purpose: name the requirement that each table row exercises.
    function automatic string row_tag(int i);
        case (i)
            0, 1, 2:  return "R11 selector setup";
            3:        return "R2 plain arm write";
            4:        return "R8 software request";
            5:        return "R5 R10 R12 completion, chain, auto-disarm";
            6, 7:     return "R11 peripheral trigger";
            8:        return "R11 unmapped pulse";
            9:        return "R6 stale flag on unmask";
            10:       return "R7 flag clear";
            11:       return "R7 completion beats clear";
            12:       return "R3 R4 abort beats completion";
            13:       return "R12 repeat setup";
            14:       return "R12 repeat keeps armed";
            15:       return "R2 arm write replaces";
            16:       return "R9 selector zero ignores pulses";
            17:       return "R8 request only armed";
            default:  return "R13 strobe one cycle";
        endcase
    endfunction

    // Purpose: compare one value and report it.
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Purpose: drive one cycle of stimulus at the falling edge and sample after the rising edge.
    task automatic step(input logic we, input logic [3:0] a, input logic [7:0] d,
                        input logic [4:0] dn, input logic [29:0] tg);
        @(negedge clk);
        wr_en_i = we; wr_addr_i = a; wr_data_i = d; done_i = dn; trig_i = tg;
        @(posedge clk);
        #1;
        wr_en_i = 1'b0; done_i = '0; trig_i = '0;
    endtask

    // Purpose: run out the watchdog; an expired watchdog counts as a failed check.
    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Purpose: main stimulus sequence.
    initial begin
        rst_n = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
        trig_i = '0; done_i = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset armed", 32'(armed_o), 32'h0);
        chk("R1 reset flags", 32'(flag_o), 32'h0);
        chk("R1 reset start/irq", {26'd0, start_o, irq_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].we, VEC[i].addr, VEC[i].data, VEC[i].done, {22'd0, VEC[i].trig});
            chk(row_tag(i), {16'd0, start_o, armed_o, flag_o, irq_o},
                {16'd0, VEC[i].e_start, VEC[i].e_armed, VEC[i].e_flag, VEC[i].e_irq});
        end

        // R10: channel 0 with selector 1 follows channel 4.
        step(1'b1, 4'd5, 8'h01, 5'h00, '0);
        step(1'b1, 4'd0, 8'h01, 5'h00, '0);
        step(1'b0, 4'd0, 8'h00, 5'h10, '0);
        chk("R10 chain wraps to channel 0", 32'(start_o), 32'h01);
        chk("R5 flag of channel 4", 32'(flag_o), 32'h1A);

        // R4: an abort that cancels channel 0's completion must not start chained channel 1.
        step(1'b1, 4'd0, 8'h02, 5'h00, '0);
        step(1'b1, 4'd0, 8'h81, 5'h01, '0);
        chk("R4 cancelled completion does not chain", 32'(start_o), 32'h00);
        chk("R4 no flag for aborted channel", 32'(flag_o), 32'h1A);
        chk("R3 unselected channel stays armed", 32'(armed_o), 32'h02);

        // R1: reset in mid-run clears everything, including the mask behind the interrupt.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 mid-run reset", {16'd0, start_o, armed_o, flag_o, irq_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 4'd0, 8'h00, 5'h01, '0);
        chk("R1 R6 mask cleared by reset", {26'd0, flag_o, irq_o}, 32'h02);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule